// File: doc/BRIEF.md
# Device Table Entry Fault Checker

This block sits between the device-table fetch and the page-table walker of an I/O address translation unit. For each translation request it takes the global translation enable, the requesting device ID, the device virtual address, an operation code, the fetched 256-bit device table entry, and a fetch-error strobe with the physical address the entry was read from. One cycle later it reports one of three outcomes. The address may pass through untranslated. The request may continue to the page walk. Or the request faults, and the block emits a 128-bit fault event record.

Two kinds of fault exist. A failed entry fetch produces a hardware-error record and also loads the hardware error register. A valid entry with reserved bits set produces an illegal-entry record. Either fault raises a bus target-abort flag, except when the operation is a command. Fetching the entry, walking page tables and queuing events to a log are handled elsewhere.

Top module: `dte_fault_check`

## Requirements
- R1: When `xlat_en` is 0, a request completes the next cycle with `done`=1, `passthru`=1 and `out_addr` equal to the request address. No event is emitted, even if `fetch_err` or reserved bits are set.
- R2: When enabled and `fetch_err` is 1, the next cycle shows `evt_valid`=1 and `hwerr_load`=1 with a hardware-error record.
- R3: When enabled, with no fetch error and entry bit 0 (valid) equal to 0, the address passes through as in R1, whatever the reserved bits hold.
- R4: When enabled and the entry is valid, a set bit of qword 0 (entry bits 63:0) outside 0x7fffffffffffff83, or of qword 1 (bits 127:64) outside 0xfffffbffffffffff, causes an illegal-entry record with `hwerr_load`=0. Qwords 2 and 3 are not checked.
- R5: A valid entry with no reserved bit set gives `done`=1 and `cont`=1, with no event and `passthru`=0.
- R6: Both records are laid out as follows. Device ID is in bits 15:0. Bit 51 is set only for interrupt (op 3). Bit 53 is set only for memory write (op 2). Bit 56 is set only for translate (op 0). The event code is in bits 63:60: parameter default 1 for illegal-entry, 3 for hardware-error. Every bit not named in R6 to R8 is 0. Op codes: translate 0, memory read 1, memory write 2, interrupt 3, command 4.
- R7: The illegal-entry record sets bit 55 and holds the device virtual address with its two low bits cleared in bits 127:64.
- R8: The hardware-error record holds a type in bits 58:57: 3 for a command, 2 otherwise. Bits 127:64 hold the fetch physical address.
- R9: `tgt_abort` is 1 with either fault unless the op is command (4). It is 0 otherwise.
- R10: A fetch error takes priority over the valid-bit and reserved-bit checks.
- R11: All outputs are single-cycle results of one request. They reset to 0 and return to 0 in a cycle that follows no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xlat_en | input | 1 | Global translation enable |
| req_valid | input | 1 | Request strobe |
| req_dev_id | input | 16 | Requesting device ID |
| req_dva | input | 64 | Device virtual address |
| req_op | input | 3 | Operation code |
| req_dte | input | 256 | Fetched device table entry |
| fetch_err | input | 1 | Entry fetch failed |
| fetch_pa | input | 64 | Physical address of the entry fetch |
| done | output | 1 | Request finished |
| passthru | output | 1 | Address forwarded untranslated |
| cont | output | 1 | Entry good, continue to page walk |
| out_addr | output | 64 | Forwarded address |
| evt_valid | output | 1 | Fault record strobe |
| evt_rec | output | 128 | Fault record |
| hwerr_load | output | 1 | Load hardware error register |
| tgt_abort | output | 1 | Signal bus target abort |

## Verification
The assertions assume that `req_op` only carries the five defined codes. They also assume that entry, address and fetch-error inputs are meaningful only in the cycle `req_valid` is high. The stimulus drives only legal op codes, changes inputs at the falling edge, and holds `req_valid` for one cycle per request. Every outcome, including the one after a request, is therefore attributable to a single set of inputs.

// File: rtl/dtefc_pkg.sv
package dtefc_pkg;
  localparam int QW_W   = 64;
  localparam int DTE_W  = 256;
  localparam int NQW    = DTE_W / QW_W;
  localparam int REC_W  = 128;
  localparam int DEV_W  = 16;
  localparam int OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_XLATE = 3'd0,
    OP_MRD   = 3'd1,
    OP_MWR   = 3'd2,
    OP_INTR  = 3'd3,
    OP_CMD   = 3'd4
  } op_e;

  localparam int BIT_INTR = 51;
  localparam int BIT_RW   = 53;
  localparam int BIT_RZ   = 55;
  localparam int BIT_TN   = 56;
  localparam int TYPE_LO  = 57;
  localparam int CODE_LO  = 60;

  localparam logic [1:0] HWT_TABORT = 2'd2;
  localparam logic [1:0] HWT_DATA   = 2'd3;

  // allowed-bit mask per qword; unchecked qwords allow everything
  function automatic logic [QW_W-1:0] qword_allow(input int idx);
    case (idx)
      0:       qword_allow = 64'h7fff_ffff_ffff_ff83;
      1:       qword_allow = 64'hffff_fbff_ffff_ffff;
      default: qword_allow = '1;
    endcase
  endfunction

  function automatic logic [REC_W-1:0] build_rec(
    input logic [DEV_W-1:0] dev,
    input logic [OP_W-1:0]  op,
    input logic [3:0]       code,
    input logic             is_hw,
    input logic [QW_W-1:0]  addr
  );
    logic [REC_W-1:0] r;
    r = '0;
    r[DEV_W-1:0]       = dev;
    r[BIT_INTR]        = (op == OP_INTR);
    r[BIT_RW]          = (op == OP_MWR);
    r[BIT_TN]          = (op == OP_XLATE);
    r[CODE_LO+3:CODE_LO] = code;
    if (is_hw) begin
      r[TYPE_LO+1:TYPE_LO] = (op == OP_CMD) ? HWT_DATA : HWT_TABORT;
      r[REC_W-1:QW_W]      = addr;
    end else begin
      r[BIT_RZ]            = 1'b1;
      r[REC_W-1:QW_W]      = {addr[QW_W-1:2], 2'b00};
    end
    return r;
  endfunction
endpackage

// File: rtl/dtefc_rsvd_scan.sv
module dtefc_rsvd_scan
  import dtefc_pkg::*;
(
  input  logic [DTE_W-1:0] dte,
  output logic             rsvd_hit
);
  logic [NQW-1:0] q_bad;
  for (genvar g = 0; g < NQW; g++) begin : g_qw
    localparam logic [QW_W-1:0] ALLOW = qword_allow(g);
    assign q_bad[g] = |(dte[g*QW_W +: QW_W] & ~ALLOW);
  end
  assign rsvd_hit = |q_bad;
endmodule

// File: rtl/dtefc_classify.sv
module dtefc_classify (
  input  logic xlat_en,
  input  logic fetch_err,
  input  logic dte_valid,
  input  logic rsvd_hit,
  output logic pass_w,
  output logic cont_w,
  output logic fault_hw_w,
  output logic fault_ill_w
);
  always_comb begin
    pass_w      = 1'b0;
    cont_w      = 1'b0;
    fault_hw_w  = 1'b0;
    fault_ill_w = 1'b0;
    if (!xlat_en)       pass_w      = 1'b1;
    else if (fetch_err) fault_hw_w  = 1'b1;
    else if (!dte_valid) pass_w     = 1'b1;
    else if (rsvd_hit)  fault_ill_w = 1'b1;
    else                cont_w      = 1'b1;
  end
endmodule

// File: rtl/dte_fault_check.sv
module dte_fault_check
  import dtefc_pkg::*;
#(
  parameter logic [3:0] CODE_ILLEGAL = 4'd1,
  parameter logic [3:0] CODE_HWERR   = 4'd3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xlat_en,
  input  logic             req_valid,
  input  logic [DEV_W-1:0] req_dev_id,
  input  logic [QW_W-1:0]  req_dva,
  input  logic [OP_W-1:0]  req_op,
  input  logic [DTE_W-1:0] req_dte,
  input  logic             fetch_err,
  input  logic [QW_W-1:0]  fetch_pa,
  output logic             done,
  output logic             passthru,
  output logic             cont,
  output logic [QW_W-1:0]  out_addr,
  output logic             evt_valid,
  output logic [REC_W-1:0] evt_rec,
  output logic             hwerr_load,
  output logic             tgt_abort
);
  logic rsvd_hit;
  logic pass_w, cont_w, fault_hw_w, fault_ill_w, fault_any_w;
  logic [REC_W-1:0] rec_w;

  dtefc_rsvd_scan u_scan (
    .dte      (req_dte),
    .rsvd_hit (rsvd_hit)
  );

  dtefc_classify u_cls (
    .xlat_en     (xlat_en),
    .fetch_err   (fetch_err),
    .dte_valid   (req_dte[0]),
    .rsvd_hit    (rsvd_hit),
    .pass_w      (pass_w),
    .cont_w      (cont_w),
    .fault_hw_w  (fault_hw_w),
    .fault_ill_w (fault_ill_w)
  );

  assign fault_any_w = fault_hw_w | fault_ill_w;
  assign rec_w = build_rec(req_dev_id, req_op,
                           fault_hw_w ? CODE_HWERR : CODE_ILLEGAL,
                           fault_hw_w,
                           fault_hw_w ? fetch_pa : req_dva);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      passthru   <= 1'b0;
      cont       <= 1'b0;
      out_addr   <= '0;
      evt_valid  <= 1'b0;
      evt_rec    <= '0;
      hwerr_load <= 1'b0;
      tgt_abort  <= 1'b0;
    end else begin
      done       <= req_valid;
      passthru   <= req_valid & pass_w;
      cont       <= req_valid & cont_w;
      out_addr   <= (req_valid & pass_w) ? req_dva : '0;
      evt_valid  <= req_valid & fault_any_w;
      evt_rec    <= (req_valid & fault_any_w) ? rec_w : '0;
      hwerr_load <= req_valid & fault_hw_w;
      tgt_abort  <= req_valid & fault_any_w & (req_op != OP_CMD);
    end
  end
endmodule

// File: rtl/dtefc_checker.sv
module dtefc_checker
  import dtefc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             xlat_en,
  input logic             req_valid,
  input logic [QW_W-1:0]  req_dva,
  input logic [OP_W-1:0]  req_op,
  input logic [DTE_W-1:0] req_dte,
  input logic             fetch_err,
  input logic             rsvd_hit,
  input logic             done,
  input logic             passthru,
  input logic             cont,
  input logic [QW_W-1:0]  out_addr,
  input logic             evt_valid,
  input logic [REC_W-1:0] evt_rec,
  input logic             hwerr_load,
  input logic             tgt_abort
);
  AST_OFF_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !xlat_en) |=> (passthru && !evt_valid && out_addr == $past(req_dva))); // R1
  AST_FETCH_ERR_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && xlat_en && fetch_err) |=> (evt_valid && hwerr_load)); // R2
  AST_INVALID_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && xlat_en && !fetch_err && !req_dte[0]) |=> passthru); // R3
  AST_RSVD_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && xlat_en && !fetch_err && req_dte[0] && rsvd_hit) |=> (evt_valid && !hwerr_load && evt_rec[55])); // R4
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot({passthru, cont, evt_valid})); // R5
  AST_ILL_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !hwerr_load) |-> (evt_rec[65:64] == 2'b00)); // R7
  AST_ABORT_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (tgt_abort == ($past(req_op) != OP_CMD))); // R9
  AST_NO_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |-> !tgt_abort); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!done && !evt_valid && !hwerr_load)); // R11
endmodule

bind dte_fault_check dtefc_checker u_chk (.*);

// File: tb/dte_fault_check_tb.sv
module dte_fault_check_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  typedef struct packed {
    logic       en;
    logic       ferr;
    logic       vbit;
    logic [1:0] rsel;   // 0 clean, 1 q0 reserved, 2 q1 reserved, 3 q2 garbage
    logic [2:0] op;
    logic [1:0] kind;   // 0 pass, 1 cont, 2 illegal, 3 hw error
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b1,2'd1,3'd0,2'd0},
    '{1'b0,1'b0,1'b1,2'd1,3'd2,2'd0},
    '{1'b1,1'b0,1'b0,2'd1,3'd0,2'd0},
    '{1'b1,1'b0,1'b1,2'd0,3'd0,2'd1},
    '{1'b1,1'b0,1'b1,2'd3,3'd1,2'd1},
    '{1'b1,1'b0,1'b1,2'd1,3'd0,2'd2},
    '{1'b1,1'b0,1'b1,2'd2,3'd2,2'd2},
    '{1'b1,1'b0,1'b1,2'd1,3'd3,2'd2},
    '{1'b1,1'b0,1'b1,2'd2,3'd4,2'd2},
    '{1'b1,1'b1,1'b1,2'd0,3'd0,2'd3},
    '{1'b1,1'b1,1'b0,2'd0,3'd4,2'd3},
    '{1'b1,1'b1,1'b1,2'd1,3'd3,2'd3},
    '{1'b1,1'b1,1'b1,2'd0,3'd2,2'd3},
    '{1'b1,1'b0,1'b1,2'd1,3'd1,2'd2}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         xlat_en = 1'b0;
  logic         req_valid = 1'b0;
  logic [15:0]  req_dev_id = '0;
  logic [63:0]  req_dva = '0;
  logic [2:0]   req_op = '0;
  logic [255:0] req_dte = '0;
  logic         fetch_err = 1'b0;
  logic [63:0]  fetch_pa = '0;
  logic         done, passthru, cont, evt_valid, hwerr_load, tgt_abort;
  logic [63:0]  out_addr;
  logic [127:0] evt_rec;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dte_fault_check u_dut (.*);

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] make_dte(input logic v, input logic [1:0] rsel);
    logic [63:0] q0, q1, q2;
    q0 = 64'h7fff_ffff_ffff_ff82 | {63'd0, v};
    q1 = 64'hffff_fbff_ffff_ffff;
    q2 = 64'd0;
    if (rsel == 2'd1) q0[2] = 1'b1;
    if (rsel == 2'd2) q1[42] = 1'b1;
    if (rsel == 2'd3) q2 = '1;
    return {64'h0, q2, q1, q0};
  endfunction

  // restated record model: set fields one by one
  function automatic logic [127:0] exp_rec(input logic hw, input logic [15:0] dev,
      input logic [2:0] op, input logic [63:0] dva, input logic [63:0] pa);
    logic [127:0] e;
    e = 128'd0;
    e[15:0] = dev;
    if (op == 3'd3) e[51] = 1'b1;
    if (op == 3'd2) e[53] = 1'b1;
    if (op == 3'd0) e[56] = 1'b1;
    if (hw) begin
      e[63:60] = 4'd3;
      e[58:57] = (op == 3'd4) ? 2'd3 : 2'd2;
      e[127:64] = pa;
    end else begin
      e[63:60] = 4'd1;
      e[55] = 1'b1;
      e[127:64] = dva & ~64'h3;
    end
    return e;
  endfunction

  task automatic check_quiet(input string tag);
    chk({tag, " done"}, {127'd0, done}, 128'd0);
    chk({tag, " evt_valid"}, {127'd0, evt_valid}, 128'd0);
    chk({tag, " hwerr_load"}, {127'd0, hwerr_load}, 128'd0);
    chk({tag, " tgt_abort"}, {127'd0, tgt_abort}, 128'd0);
    chk({tag, " passthru/cont"}, {126'd0, passthru, cont}, 128'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_quiet("R11 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_quiet("R11 idle after reset");

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [63:0] dva, pa;
      logic [15:0] dev;
      string tg;
      v   = VECS[i];
      dva = (64'h1234_5678_9abc_def0 ^ (64'(i) * 64'h1111_0000)) | 64'h3;
      pa  = 64'hfeed_0000_0000_0000 + 64'(i) * 64'd32;
      dev = 16'ha000 + 16'(i);
      tg  = (v.kind == 2'd0) ? (v.en ? "R3" : "R1") :
            (v.kind == 2'd1) ? "R5" :
            (v.kind == 2'd2) ? "R4" : (v.vbit && v.rsel == 2'd1 ? "R10" : "R2");
      xlat_en    = v.en;
      fetch_err  = v.ferr;
      req_dte    = make_dte(v.vbit, v.rsel);
      req_op     = v.op;
      req_dva    = dva;
      req_dev_id = dev;
      fetch_pa   = pa;
      req_valid  = 1'b1;
      @(negedge clk);
      req_valid  = 1'b0;
      chk($sformatf("%s v%0d done", tg, i), {127'd0, done}, 128'd1);
      chk($sformatf("%s v%0d passthru", tg, i), {127'd0, passthru}, {127'd0, v.kind == 2'd0});
      chk($sformatf("%s v%0d cont", tg, i), {127'd0, cont}, {127'd0, v.kind == 2'd1});
      chk($sformatf("%s v%0d evt_valid", tg, i), {127'd0, evt_valid}, {127'd0, v.kind[1]});
      chk($sformatf("%s v%0d hwerr_load", tg, i), {127'd0, hwerr_load}, {127'd0, v.kind == 2'd3});
      chk($sformatf("R9 v%0d tgt_abort", i), {127'd0, tgt_abort},
          {127'd0, v.kind[1] && v.op != 3'd4});
      if (v.kind == 2'd0)
        chk($sformatf("R1 v%0d out_addr", i), {64'd0, out_addr}, {64'd0, dva});
      if (v.kind[1])
        chk($sformatf("R6 R7 R8 v%0d evt_rec", i), evt_rec,
            exp_rec(v.kind == 2'd3, dev, v.op, dva, pa));
    end

    // R11: strobes fall the cycle after a fault when no request follows
    xlat_en = 1'b1; fetch_err = 1'b1; req_op = 3'd1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 single fault strobe", {127'd0, evt_valid}, 128'd1);
    @(negedge clk);
    check_quiet("R11 after fault");

    // R11: inputs that would fault have no effect without req_valid
    fetch_err = 1'b0;
    req_dte = make_dte(1'b1, 2'd1);
    @(negedge clk);
    check_quiet("R11 no request");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule